// File: doc/BRIEF.md
# Masked-Access GPIO Port with Interrupt Detection

This block is an eight-pin general-purpose I/O port sitting on a simple memory-mapped register bus. Each pin is independently an input or an output. Pin data is reached through a 256-word data window whose address bits double as a per-pin bit mask. Software can therefore set or read any subset of pins with one access, without a read-modify-write sequence.

Every pin can raise an interrupt. The trigger is chosen by three configuration registers: level or edge sense, polarity, and a both-edges override. The block exposes raw status, masked status, an interrupt-enable register and a write-one-to-clear register. All masked status bits merge into one registered interrupt line.

Inputs are brought into the clock domain by a multi-flop synchroniser before they are used for reads or detection. A read-only identification word is also provided.

Top module: `gpio_mask_irq`

## Requirements
- R1: After reset, all pins are inputs (`pin_oe` = 0), `pin_out` = 0, `irq` = 0, and the direction, sense, both-edge, event and enable registers (byte offsets 0x400, 0x404, 0x408, 0x40C, 0x410) read 0.
- R2: The direction register at offset 0x400 holds one bit per pin; a 1 makes that pin an output, and `pin_oe` shows the register value from the cycle after the write.
- R3: A write at offset 0x000 to 0x3FC changes only the output latches of pins whose bit in address bits [9:2] is 1.
- R4: A data-window write leaves the output latch of a pin that is an input unchanged. The same write repeated after the pin is made an output takes effect.
- R5: A data-window read returns the value driven for output pins and the synchronised input for input pins, with 0 in every bit whose address mask bit [9:2] is 0. Read data appears on `bus_rdata` in the cycle after the read access.
- R6: With sense bit 1 (offset 0x404), a pin's raw status (offset 0x414) is 1 while its synchronised input equals its event bit (offset 0x40C, 1 = high, 0 = low). Writing the clear register does not remove it while the level persists.
- R7: With sense bit 0 and both-edge bit 0, event bit 1 latches raw status on a rising edge and event bit 0 latches it on a falling edge. The edge of the other direction is ignored, and the status stays set after the input returns.
- R8: With sense bit 0 and both-edge bit 1 (offset 0x408), a pin latches raw status on rising and on falling edges, whatever its event bit.
- R9: Writing 1 to a bit of the clear register at offset 0x41C clears that pin's latched edge status. Bits written 0 are untouched, and the register reads 0.
- R10: Masked status (offset 0x418) is raw status ANDed with the enable register (offset 0x410). `irq` is the OR of the masked status bits, delayed by one register.
- R11: The identification word at offset 0x420 reads 0x00041061 in its low 20 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 8 | Pin inputs from the pads |
| pin_out | output | 8 | Output latch values |
| pin_oe | output | 8 | Output enable per pin |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The data window is tried with full masks, sparse masks and mixed input and output pins. This separates a mask applied on the address from one applied on the direction, and shows that a write to an input pin is dropped. Interrupt detection is driven with a high level, a low level, a rising edge, a falling edge under both polarities, and both edges on one pin. These cases separate level from latched behaviour, rising from falling selection, and the both-edges override. Clearing a level pin and clearing an edge pin show that the clear register acts only on latched status. Changing the enable register while status is pending separates raw status from masked status and from the interrupt line.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned BUS_AW  = 12;
   localparam int unsigned BUS_DW  = 32;
   localparam int unsigned WORD_AW = BUS_AW - 2;

   // word indices (byte offset / 4) of the control registers
   localparam logic [WORD_AW-1:0] W_DIR   = 10'h100;
   localparam logic [WORD_AW-1:0] W_SENSE = 10'h101;
   localparam logic [WORD_AW-1:0] W_BOTH  = 10'h102;
   localparam logic [WORD_AW-1:0] W_EVENT = 10'h103;
   localparam logic [WORD_AW-1:0] W_EN    = 10'h104;
   localparam logic [WORD_AW-1:0] W_RAW   = 10'h105;
   localparam logic [WORD_AW-1:0] W_MSK   = 10'h106;
   localparam logic [WORD_AW-1:0] W_CLR   = 10'h107;
   localparam logic [WORD_AW-1:0] W_IDENT = 10'h108;

   typedef struct packed {
      logic [7:0] dir;
      logic [7:0] sense;
      logic [7:0] both;
      logic [7:0] event_pol;
      logic [7:0] en;
   } gpio_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned NPIN   = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] d_in,
   output logic [NPIN-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [NPIN-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d_in;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int unsigned NPIN = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_sync,
   input  logic [NPIN-1:0] sense,
   input  logic [NPIN-1:0] both,
   input  logic [NPIN-1:0] event_pol,
   input  logic [NPIN-1:0] clr,
   output logic [NPIN-1:0] raw
);
   logic [NPIN-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else prev_q <= pin_sync;
   end

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      logic rise, fall, hit, latch_q;
      assign rise = pin_sync[i] & ~prev_q[i];
      assign fall = ~pin_sync[i] & prev_q[i];
      assign hit  = both[i] ? (rise | fall) : (event_pol[i] ? rise : fall);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) latch_q <= 1'b0;
         else if (!sense[i] && hit) latch_q <= 1'b1;
         else if (clr[i]) latch_q <= 1'b0;
      end

      assign raw[i] = sense[i] ? (pin_sync[i] == event_pol[i]) : latch_q;
   end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int unsigned        NPIN     = 8,
   parameter logic [BUS_DW-1:0]  ID_VALUE = 32'h0004_1061
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic [NPIN-1:0]   pin_sync,
   input  logic [NPIN-1:0]   raw,
   input  logic [NPIN-1:0]   mis,
   output gpio_cfg_t         cfg,
   output logic [NPIN-1:0]   dout,
   output logic [NPIN-1:0]   clr
);
   localparam int unsigned MASK_LO = 2;
   localparam int unsigned MASK_HI = MASK_LO + NPIN - 1;

   logic [WORD_AW-1:0] widx;
   logic               in_win, do_wr, do_rd;
   logic [NPIN-1:0]    amask, wbits, pin_view;
   logic [BUS_DW-1:0]  rd_next;

   assign widx   = bus_addr[BUS_AW-1:2];
   assign in_win = (bus_addr[BUS_AW-1:10] == '0);
   assign do_wr  = bus_sel & bus_wr;
   assign do_rd  = bus_sel & ~bus_wr;
   assign amask  = bus_addr[MASK_HI:MASK_LO];
   assign wbits  = bus_wdata[NPIN-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (do_wr) begin
         case (widx)
            W_DIR:   cfg.dir       <= wbits;
            W_SENSE: cfg.sense     <= wbits;
            W_BOTH:  cfg.both      <= wbits;
            W_EVENT: cfg.event_pol <= wbits;
            W_EN:    cfg.en        <= wbits;
            default: ;
         endcase
      end
   end

   // pin latch: only pins selected by the address and driven as outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else if (do_wr && in_win)
         dout <= (dout & ~(amask & cfg.dir)) | (wbits & amask & cfg.dir);
   end

   assign clr = (do_wr && widx == W_CLR) ? wbits : '0;

   assign pin_view = (cfg.dir & dout) | (~cfg.dir & pin_sync);

   always_comb begin
      rd_next = '0;
      if (in_win) begin
         rd_next[NPIN-1:0] = pin_view & amask;
      end else begin
         case (widx)
            W_DIR:   rd_next[NPIN-1:0] = cfg.dir;
            W_SENSE: rd_next[NPIN-1:0] = cfg.sense;
            W_BOTH:  rd_next[NPIN-1:0] = cfg.both;
            W_EVENT: rd_next[NPIN-1:0] = cfg.event_pol;
            W_EN:    rd_next[NPIN-1:0] = cfg.en;
            W_RAW:   rd_next[NPIN-1:0] = raw;
            W_MSK:   rd_next[NPIN-1:0] = mis;
            W_IDENT: rd_next           = ID_VALUE;
            default: rd_next           = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else if (do_rd) bus_rdata <= rd_next;
   end
endmodule

// File: rtl/gpio_mask_irq.sv
module gpio_mask_irq #(
   parameter int unsigned NPIN        = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [11:0] bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic [7:0]  pin_in,
   output logic [7:0]  pin_out,
   output logic [7:0]  pin_oe,
   output logic        irq
);
   import gpio_pkg::*;

   if (NPIN != 8) begin : g_bad_npin
      $error("gpio_mask_irq: address mask field fixes NPIN at 8");
   end

   gpio_cfg_t       cfg;
   logic [NPIN-1:0] pin_sync, raw_w, mis_w, dout_w, clr_w;
   logic            irq_q;

   gpio_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_sync(pin_sync)
   );

   gpio_irq_detect #(.NPIN(NPIN)) u_det (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync),
      .sense(cfg.sense), .both(cfg.both), .event_pol(cfg.event_pol),
      .clr(clr_w), .raw(raw_w)
   );

   assign mis_w = raw_w & cfg.en;

   gpio_regs #(.NPIN(NPIN)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_sync(pin_sync), .raw(raw_w), .mis(mis_w),
      .cfg(cfg), .dout(dout_w), .clr(clr_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else irq_q <= |mis_w;
   end

   assign irq     = irq_q;
   assign pin_out = dout_w;
   assign pin_oe  = cfg.dir;
endmodule

// File: rtl/gpio_mask_irq_chk.sv
module gpio_mask_irq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_sel,
   input logic        bus_wr,
   input logic [11:0] bus_addr,
   input logic [31:0] bus_wdata,
   input logic [31:0] bus_rdata,
   input logic [7:0]  pin_out,
   input logic [7:0]  pin_oe,
   input logic        irq,
   input logic [7:0]  mis
);
   logic win_wr, dir_wr, id_rd;
   assign win_wr = bus_sel && bus_wr && (bus_addr[11:10] == 2'b00);
   assign dir_wr = bus_sel && bus_wr && (bus_addr == 12'h400);
   assign id_rd  = bus_sel && !bus_wr && (bus_addr == 12'h420);

   a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
      dir_wr |=> pin_oe == $past(bus_wdata[7:0]));

   a_r3_addr_mask: assert property (@(posedge clk) disable iff (!rst_n)
      win_wr |=> ((pin_out ^ $past(pin_out)) & ~$past(bus_addr[9:2])) == 8'h00);

   a_r4_input_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      win_wr |=> ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == 8'h00);

   a_r10_irq_delay: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|mis));

   a_r11_ident: assert property (@(posedge clk) disable iff (!rst_n)
      id_rd |=> bus_rdata[19:0] == 20'h41061);
endmodule

bind gpio_mask_irq gpio_mask_irq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .mis(mis_w)
);

// File: tb/sim_gpio_mask_irq.sv
module sim_gpio_mask_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = '0, pin_out, pin_oe;
   logic        irq;

   int n_checks = 0, n_errors = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        mon_pend = 1'b0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_mask_irq u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   // monitor: compares read data one cycle after each read access
   always @(posedge clk) mon_pend <= bus_sel & ~bus_wr;

   always @(negedge clk) begin
      if (mon_pend && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_checks++;
         if (bus_rdata !== e) begin
            n_errors++;
            $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      bus_sel = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
      n_checks++;
      if (act !== e) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", t, act, e);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #200_000;
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      settle(3);
      rst_n = 1'b1;
      settle(1);
      // R1 reset state
      chk(pin_oe, 0, "R1 oe");
      chk(pin_out, 0, "R1 out");
      chk(irq, 0, "R1 irq");
      rd(12'h400, 0, "R1 dir");
      rd(12'h404, 0, "R1 sense");
      rd(12'h40C, 0, "R1 event");
      rd(12'h410, 0, "R1 enable");
      // R4 write to input pins ignored
      wr(12'h3FC, 32'hFF);
      chk(pin_out, 0, "R4 write to inputs");
      // R2 direction
      wr(12'h400, 32'h0F);
      chk(pin_oe, 8'h0F, "R2 oe");
      rd(12'h400, 32'h0F, "R2 dir readback");
      // R3 masked writes
      wr(12'h014, 32'hFF);
      chk(pin_out, 8'h05, "R3 sparse mask");
      wr(12'h3FC, 32'h0A);
      chk(pin_out, 8'h0A, "R3 full mask");
      wr(12'h3FC, 32'hF0);
      chk(pin_out, 8'h00, "R4 upper pins still inputs");
      // R4 repeat after switching to output
      wr(12'h400, 32'hFF);
      wr(12'h3FC, 32'hF0);
      chk(pin_out, 8'hF0, "R4 rewrite after output");
      wr(12'h400, 32'h0F);
      // R5 masked reads, mixed directions
      pin_in = 8'hA5;
      settle(4);
      rd(12'h3FC, 32'hA0, "R5 full read");
      rd(12'h0C0, 32'h20, "R5 masked read");
      rd(12'h00C, 32'h00, "R5 low pins driven 0");
      // interrupt setup: p4 level high, p5 level low, p6 rising, p7 both
      wr(12'h404, 32'h30);
      wr(12'h40C, 32'h50);
      wr(12'h408, 32'h80);
      wr(12'h41C, 32'hFF);
      rd(12'h414, 32'h00, "R6 idle raw");
      // R6 level high
      pin_in = 8'hB5;
      settle(4);
      rd(12'h414, 32'h10, "R6 high level raw");
      rd(12'h418, 32'h00, "R10 disabled masked");
      chk(irq, 0, "R10 irq disabled");
      wr(12'h410, 32'h10);
      settle(2);
      chk(irq, 1, "R10 irq enabled");
      rd(12'h418, 32'h10, "R10 masked");
      wr(12'h41C, 32'h10);
      rd(12'h414, 32'h10, "R6 level not clearable");
      pin_in = 8'hA5;
      settle(4);
      rd(12'h414, 32'h00, "R6 level gone");
      chk(irq, 0, "R10 irq drops");
      // R6 level low
      pin_in = 8'h85;
      settle(4);
      rd(12'h414, 32'h20, "R6 low level raw");
      pin_in = 8'hA5;
      settle(4);
      // R7 rising edge latched
      pin_in = 8'hE5;
      settle(4);
      rd(12'h414, 32'h40, "R7 rising");
      pin_in = 8'hA5;
      settle(4);
      rd(12'h414, 32'h40, "R7 latched after return");
      wr(12'h41C, 32'h40);
      rd(12'h414, 32'h00, "R9 clear edge");
      // R7 falling polarity
      wr(12'h40C, 32'h10);
      pin_in = 8'hE5;
      settle(4);
      rd(12'h414, 32'h00, "R7 rising ignored in falling mode");
      pin_in = 8'hA5;
      settle(4);
      rd(12'h414, 32'h40, "R7 falling");
      wr(12'h41C, 32'h80);
      rd(12'h414, 32'h40, "R9 other bit untouched");
      wr(12'h41C, 32'h40);
      // R8 both edges on p7
      pin_in = 8'h25;
      settle(4);
      rd(12'h414, 32'h80, "R8 falling");
      wr(12'h41C, 32'h80);
      rd(12'h414, 32'h00, "R9 clear both");
      pin_in = 8'hA5;
      settle(4);
      rd(12'h414, 32'h80, "R8 rising");
      rd(12'h41C, 32'h00, "R9 reads zero");
      // R10 enable selects
      wr(12'h410, 32'h40);
      settle(2);
      chk(irq, 0, "R10 other pin enabled");
      rd(12'h418, 32'h00, "R10 masked other");
      wr(12'h410, 32'h80);
      settle(2);
      chk(irq, 1, "R10 p7 enabled");
      // R11 identification
      rd(12'h420, 32'h00041061, "R11 ident");
      settle(3);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule